// File: doc/BRIEF.md
# Ring-Oscillator Phase Transition Counter

This block is the digital back end of a time-domain quantizer built around a ring oscillator. On each sampling clock edge it captures the level of every ring tap. It compares each captured level with the level the same tap had one period earlier. A tap whose level differs has switched during the last period, so the comparison acts as a first-order difference of the sampled oscillator phase.

The per-tap change flags leave the block as a unit-element vector that can drive feedback DAC cells directly. The transition wave travels around the ring, so the set of active cells rotates from period to period. This gives element averaging without a separate shuffler.

The flags are also summed into a binary code equal to the number of stages that toggled, which tracks the input-controlled oscillator frequency. A ring of N stages gives N+1 code values. No more than N transitions fit in one period, so the oscillator must stay below half the sample rate. A flag reports a period in which every stage toggled, because the limit may then have been crossed. An optional two-flop synchronizer on the taps handles their asynchrony to the sampling clock.

Top module: `ring_phase_counter`

## Requirements
- R1: While rst_ni is low, elem_o, code_o and over_o are all 0, and the tap history is cleared to all zeros.
- R2: Bit i of elem_o is 1 exactly when tap i's sample differs from its sample one clock earlier. With SYNC_STAGES synchronizer flops, a tap change applied before clock edge k shows on elem_o after edge k+SYNC_STAGES.
- R3: code_o equals the number of ones that elem_o held in the previous cycle, as an unsigned binary value $clog2(N+1) bits wide.
- R4: When the ring advances a constant K stage transitions per sampling period, for any K from 0 to N, code_o settles to K.
- R5: over_o is 1 exactly in the cycles where code_o equals N, meaning every elem_o bit was set in the same period. Its timing matches code_o.
- R6: With SYNC_STAGES = 2, a single step of J transitions after an idle ring appears as J set bits on elem_o exactly 3 clocks after the step and as code_o = J exactly 4 clocks after. All other cycles read zero.
- R7: At a constant rate K, over any N consecutive periods each elem_o bit is set exactly K times.
- R8: The first sample after reset is compared against the all-zero history. A tap pattern P held through and after reset appears once on elem_o as P, SYNC_STAGES+1 clocks after release, and as zero afterwards.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | N | Ring oscillator tap levels |
| elem_o | output | N | Unit-element vector of stages that toggled in the last period |
| code_o | output | $clog2(N+1) | Count of toggled stages |
| over_o | output | 1 | All stages toggled in the period (frequency limit reached) |

## Verification
A tap change applied before an edge is due on elem_o SYNC_STAGES+1 edges later. The code and the overrange flag follow one edge after that. The bench drives the taps on the falling edge and samples every output on the next falling edge. Its behavioural model routes each applied tap vector through a queue as long as the synchronizer before differencing it, so the model lines up with the design's cycle on every clock. Separate timed probes count cycles after a single step and after reset release, and check that the result lands in the one due cycle and nowhere else.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  function automatic int unsigned code_width(input int unsigned stages);
    return $clog2(stages + 1);
  endfunction
endpackage

// File: rtl/tap_sync.sv
module tap_sync #(
  parameter int unsigned N      = 15,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] d_o
);
  if (STAGES == 0) begin : g_bypass
    assign d_o = d_i;
  end else begin : g_flops
    logic [STAGES-1:0][N-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pipe_q <= '0;
      end else begin
        pipe_q[0] <= d_i;
        for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
      end
    end
    assign d_o = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/toggle_detect.sv
module toggle_detect #(
  parameter int unsigned N = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] elem_o
);
  logic [N-1:0] samp_q;
  logic [N-1:0] elem_q;

  // difference of sampled phase: new sample vs. held one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
      elem_q <= '0;
    end else begin
      samp_q <= d_i;
      elem_q <= d_i ^ samp_q;
    end
  end

  assign elem_o = elem_q;

  // R2
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $stable(d_i) |=> elem_q == '0);
endmodule

// File: rtl/code_sum.sv
module code_sum #(
  parameter int unsigned N  = 15,
  parameter int unsigned CW = rpc_pkg::code_width(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  elem_i,
  output logic [CW-1:0] code_o,
  output logic          over_o
);
  logic [CW-1:0] sum_d;
  logic [CW-1:0] code_q;
  logic          over_q;

  always_comb begin
    sum_d = '0;
    for (int i = 0; i < N; i++) sum_d = sum_d + CW'(elem_i[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      over_q <= 1'b0;
    end else begin
      code_q <= sum_d;
      over_q <= &elem_i;
    end
  end

  assign code_o = code_q;
  assign over_o = over_q;

  // R3
  code_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q == CW'($countones($past(elem_i))));

  // R5
  over_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_q == (code_q == CW'(N)));

  // R3
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $stable(elem_i) |=> $stable(code_q));
endmodule

// File: rtl/ring_phase_counter.sv
module ring_phase_counter #(
  parameter int unsigned N           = 15,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW         = rpc_pkg::code_width(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  phase_i,
  output logic [N-1:0]  elem_o,
  output logic [CW-1:0] code_o,
  output logic          over_o
);
  logic [N-1:0] phase_s;

  tap_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (phase_i),
    .d_o   (phase_s)
  );

  toggle_detect #(.N(N)) u_diff (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (phase_s),
    .elem_o(elem_o)
  );

  code_sum #(.N(N), .CW(CW)) u_sum (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .elem_i(elem_o),
    .code_o(code_o),
    .over_o(over_o)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (elem_o == '0 && code_o == '0 && !over_o));
endmodule

// File: tb/sim_ring_phase_counter.sv
module sim_ring_phase_counter;
  localparam int unsigned N    = 15;
  localparam int unsigned SYNC = 2;
  localparam int unsigned CW   = $clog2(N + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  phase_i = '0;
  logic [N-1:0]  elem_o;
  logic [CW-1:0] code_o;
  logic          over_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  longint ph = 0;

  logic [N-1:0] dq[$];
  logic [N-1:0] m_samp, m_elem;
  int           m_code;
  logic         m_over;

  always #2.5 clk_i = ~clk_i;

  ring_phase_counter #(.N(N), .SYNC_STAGES(SYNC)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_i(phase_i),
    .elem_o(elem_o), .code_o(code_o), .over_o(over_o)
  );

  initial begin
    while (cyc < 150000) begin
      @(posedge clk_i);
      cyc++;
    end
    n_bad++;
    $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic logic [N-1:0] taps(input longint p);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) begin
      longint hits = (p > i) ? ((p - i - 1) / N + 1) : 0;
      v[i] = hits[0];
    end
    return v;
  endfunction

  task automatic check(input string tag, input longint got, input longint exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic model_reset();
    dq = {};
    for (int i = 0; i < int'(SYNC); i++) dq.push_back('0);
    m_samp = '0; m_elem = '0; m_code = 0; m_over = 1'b0;
  endtask

  task automatic model_step();
    logic [N-1:0] d;
    if (!rst_ni) begin
      model_reset();
    end else begin
      if (SYNC == 0) d = phase_i;
      else begin
        d = dq.pop_front();
        dq.push_back(phase_i);
      end
      m_code = $countones(m_elem);
      m_over = (m_elem == {N{1'b1}});
      m_elem = d ^ m_samp;
      m_samp = d;
    end
  endtask

  // one clock: edge, model update, compare at the falling edge
  task automatic tick();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    check("R2 elem_o", elem_o, m_elem);
    check("R3 code_o", code_o, m_code);
    check("R5 over_o", over_o, m_over);
  endtask

  task automatic run(input int k, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      ph += k;
      phase_i = taps(ph);
      tick();
    end
  endtask

  initial begin
    int use_cnt [N];
    logic [N-1:0] pat;
    model_reset();
    @(negedge clk_i);
    phase_i = '0;
    for (int c = 0; c < 3; c++) tick();
    // R1
    check("R1 elem_o in reset", elem_o, 0);
    check("R1 code_o in reset", code_o, 0);
    check("R1 over_o in reset", over_o, 0);
    rst_ni = 1'b1;

    // R4: every constant rate
    for (int k = 0; k <= int'(N); k++) begin
      run(k, 10);
      check("R4 code_o at constant rate", code_o, k);
      check("R5 over_o at constant rate", over_o, (k == int'(N)) ? 1 : 0);
    end

    // R6: single step of 3 transitions after idle
    run(0, 8);
    ph += 3;
    phase_i = taps(ph);
    for (int i = 1; i <= 6; i++) begin
      tick();
      check("R6 elem_o step timing", $countones(elem_o), (i == int'(SYNC) + 1) ? 3 : 0);
      check("R6 code_o step timing", code_o, (i == int'(SYNC) + 2) ? 3 : 0);
    end

    // R7: rotation, each element used K times in N periods
    run(5, 8);
    for (int i = 0; i < int'(N); i++) use_cnt[i] = 0;
    for (int c = 0; c < int'(N); c++) begin
      run(5, 1);
      for (int i = 0; i < int'(N); i++) use_cnt[i] += int'(elem_o[i]);
    end
    for (int i = 0; i < int'(N); i++) check("R7 element use count", use_cnt[i], 5);

    // varying rate pattern
    for (int c = 0; c < 48; c++) run((c * 7) % (int'(N) + 1), 1);

    // R8: pattern held through reset
    ph = 4;
    pat = taps(ph);
    phase_i = pat;
    rst_ni = 1'b0;
    for (int c = 0; c < 2; c++) tick();
    check("R1 code_o in mid-run reset", code_o, 0);
    rst_ni = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      tick();
      check("R8 first difference after reset", elem_o, (i == int'(SYNC) + 1) ? pat : '0);
    end
    run(N, 6);
    check("R5 over_o at full rate", over_o, 1);
    run(2, 6);
    check("R4 code_o after full rate", code_o, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule